// File: doc/BRIEF.md
# Control-Register Port Responder

This block is the register-side end of a narrow strobed configuration port. A master drives one shared 16-bit input field together with four separate strobes. Two strobes load that field into an address holding register or a data holding register. The other two start a write or a read at the held address. Every strobe is answered with a four-phase handshake: the acknowledge rises after a configurable number of cycles and stays high until the master withdraws the strobe.

Behind the port is a sparse register file. Only a few 16-bit addresses hold storage. Any other address is still acknowledged, but writes to it are dropped and reads from it return zero. Read data appears on a 16-bit output field and is held there until the next read.

The block has two aids for checking a master. A strobe word with more than one command bit set does nothing except raise a sticky error flag. A mute input stops the acknowledge completely, so the master's timeout handling can be exercised.

Top module: `cfg_port_responder`

## Requirements
- R1: After reset, `ack`, `rd_data` and `err_flag` are 0. The register at 0x0015 reads 0x0009: bias field [15:13]=0, enable bit 10 clear, level field [4:0]=9. The register at 0x0012 reads 0x8000: boost field [15:13]=4. The register at 0x1010 reads 0x0080.
- R2: An acknowledged `stb_addr` loads the address holding register from the value `wr_field` had on the first clock edge that sampled the strobe. An acknowledged `stb_data` loads the data holding register in the same way.
- R3: Take the first rising edge that samples a strobe high from idle as edge 0. With default `ACK_DELAY`=2, `ack` goes high right after edge `ACK_DELAY`.
- R4: Once `ack` is high, it stays high while any strobe is high. It falls on the first edge that samples all four strobes low.
- R5: An acknowledged `stb_wr` stores the data holding register into the implemented register selected by the address holding register.
- R6: An acknowledged `stb_rd` loads `rd_data` from the held address. `rd_data` keeps that value until the next acknowledged read.
- R7: An access to an unimplemented address is acknowledged. A write to it changes no implemented register, and a read from it returns 0.
- R8: A strobe word with two or more strobes high is acknowledged after the same delay. It changes neither holding register, no implemented register and not `rd_data`. It sets `err_flag`, which stays set until reset.
- R9: While `ack_mute` is high, `ack` never rises and the pending command does not take effect. When the strobes drop, the block returns to idle and performs no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_field | input | 16 | Shared address/data input field |
| stb_addr | input | 1 | Capture-address strobe |
| stb_data | input | 1 | Capture-data strobe |
| stb_rd | input | 1 | Read strobe |
| stb_wr | input | 1 | Write strobe |
| ack_mute | input | 1 | Test input that suppresses acknowledge |
| ack | output | 1 | Four-phase acknowledge |
| rd_data | output | 16 | Read data output field |
| err_flag | output | 1 | Sticky flag for a strobe word with more than one command |

## Verification
The assertions assume the master keeps to four-phase order. It raises strobes only while `ack` is low, and it holds `wr_field` and the strobes steady until `ack` rises or until it abandons a muted access. The bench drives every input on the falling clock edge. It waits for `ack` before releasing a strobe, and waits for `ack` to fall before the next strobe. It breaks this order only on purpose, by raising several strobes at once and by muting the acknowledge.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int NCMD = 4;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_COUNT = 2'd1,
    HS_ACK   = 2'd2
  } hs_state_e;

  // command bit order: [3]=write [2]=read [1]=capture data [0]=capture address
  localparam int CMD_ADDR = 0;
  localparam int CMD_DATA = 1;
  localparam int CMD_RD   = 2;
  localparam int CMD_WR   = 3;

  function automatic logic cmd_any(input logic [NCMD-1:0] c);
    return c != '0;
  endfunction

  // more than one bit set: clearing the lowest set bit leaves something
  function automatic logic cmd_multi(input logic [NCMD-1:0] c);
    return (c & (c - NCMD'(1))) != '0;
  endfunction
endpackage

// File: rtl/cpr_handshake.sv
module cpr_handshake
  import cpr_pkg::*;
#(
  parameter int ACK_DELAY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMD-1:0] cmd_in,
  input  logic            mute,
  output logic            ack,
  output logic            take,
  output logic            fire,
  output logic [NCMD-1:0] cmd_q
);
  localparam int CW = $clog2(ACK_DELAY + 1) + 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_DELAY);

  hs_state_e       state;
  logic [CW-1:0]   cnt;
  logic            any_now;
  logic            cnt_done;

  assign any_now  = cmd_any(cmd_in);
  assign cnt_done = (cnt == CNT_LAST);
  assign take     = (state == HS_IDLE) && any_now;
  assign fire     = (state == HS_COUNT) && any_now && cnt_done && !mute;
  assign ack      = (state == HS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_IDLE;
      cnt   <= '0;
      cmd_q <= '0;
    end else begin
      case (state)
        HS_IDLE: begin
          if (any_now) begin
            state <= HS_COUNT;
            cnt   <= CW'(1);
            cmd_q <= cmd_in;
          end
        end
        HS_COUNT: begin
          if (!any_now) begin
            state <= HS_IDLE;
          end else if (fire) begin
            state <= HS_ACK;
          end else if (!cnt_done) begin
            cnt <= cnt + CW'(1);
          end
        end
        HS_ACK: begin
          if (!any_now) state <= HS_IDLE;
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && any_now) |=> ack);
  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> !$past(any_now));
  assert_ack_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(any_now));
  assert_mute_blocks_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> !$past(mute));
endmodule

// File: rtl/cpr_regbank.sv
module cpr_regbank
  import cpr_pkg::*;
#(
  parameter int              N_REGS = 3,
  parameter logic [N_REGS*AW-1:0] ADDRS = {16'h1010, 16'h0012, 16'h0015},
  parameter logic [N_REGS*DW-1:0] RSTS  = {16'h0080, 16'h8000, 16'h0009}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [N_REGS-1:0]    hit_vec;
  logic [N_REGS*DW-1:0] q_flat;
  logic [DW-1:0]        rd_val;
  logic                 hit_any;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic [DW-1:0] q;
    assign hit_vec[i] = (addr == ADDRS[i*AW +: AW]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RSTS[i*DW +: DW];
      else if (wr_en && hit_vec[i]) q <= wdata;
    end
    assign q_flat[i*DW +: DW] = q;
  end

  assign hit_any = |hit_vec;

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_REGS; i++)
      if (hit_vec[i]) rd_val = rd_val | q_flat[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assert_unmapped_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_any) |=> $stable(q_flat));
  assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_any) |=> (rdata == '0));
  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  assert_mapped_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_any) |=> $changed(q_flat) || $past(rd_val) == $past(wdata));
endmodule

// File: rtl/cfg_port_responder.sv
module cfg_port_responder
  import cpr_pkg::*;
#(
  parameter int ACK_DELAY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   wr_field,
  input  logic          stb_addr,
  input  logic          stb_data,
  input  logic          stb_rd,
  input  logic          stb_wr,
  input  logic          ack_mute,
  output logic          ack,
  output logic [15:0]   rd_data,
  output logic          err_flag
);
  logic [NCMD-1:0] cmd_in;
  logic [NCMD-1:0] cmd_q;
  logic            take;
  logic            fire;
  logic            multi_q;
  logic            act;
  logic [DW-1:0]   field_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;

  assign cmd_in = {stb_wr, stb_rd, stb_data, stb_addr};

  cpr_handshake #(.ACK_DELAY(ACK_DELAY)) u_hs (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_in (cmd_in),
    .mute   (ack_mute),
    .ack    (ack),
    .take   (take),
    .fire   (fire),
    .cmd_q  (cmd_q)
  );

  assign multi_q = cmd_multi(cmd_q);
  assign act     = fire && !multi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q  <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      err_flag <= 1'b0;
    end else begin
      if (take) field_q <= wr_field;
      if (act && cmd_q[CMD_ADDR]) addr_q <= field_q;
      if (act && cmd_q[CMD_DATA]) data_q <= field_q;
      if (fire && multi_q) err_flag <= 1'b1;
    end
  end

  cpr_regbank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (act && cmd_q[CMD_WR]),
    .rd_en (act && cmd_q[CMD_RD]),
    .addr  (addr_q),
    .wdata (data_q),
    .rdata (rd_data)
  );

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_flag));
  assert_multi_no_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && multi_q) |=> $stable(addr_q) && $stable(data_q) && $stable(rd_data));
  assert_no_action_without_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ack) |-> $stable(addr_q) && $stable(data_q));
endmodule

// File: tb/cfg_port_responder_tb.sv
module cfg_port_responder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wr_field = '0;
  logic        stb_addr = 0, stb_data = 0, stb_rd = 0, stb_wr = 0;
  logic        ack_mute = 0;
  logic        ack;
  logic [15:0] rd_data;
  logic        err_flag;

  int total = 0;
  int bad = 0;

  localparam int DLY = 2;

  cfg_port_responder #(.ACK_DELAY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_field(wr_field),
    .stb_addr(stb_addr), .stb_data(stb_data), .stb_rd(stb_rd), .stb_wr(stb_wr),
    .ack_mute(ack_mute), .ack(ack), .rd_data(rd_data), .err_flag(err_flag)
  );

  always #10 clk = ~clk;

  logic [15:0] map_addr [3];
  logic [15:0] model    [3];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cmd order {wr, rd, data, addr}
  task automatic xfer(input logic [3:0] c, input logic [15:0] d);
    int lat;
    bit held;
    @(negedge clk);
    {stb_wr, stb_rd, stb_data, stb_addr} = c;
    wr_field = d;
    lat = -1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (ack) begin lat = n; break; end
    end
    check(lat == DLY + 1, "R3 ack latency", lat, DLY + 1);
    held = 1;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      if (!ack) held = 0;
    end
    check(held, "R4 ack held with strobe", held, 1);
    {stb_wr, stb_rd, stb_data, stb_addr} = 4'b0000;
    wr_field = 16'hDEAD;
    @(negedge clk);
    check(!ack, "R4 ack released", ack, 0);
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
    xfer(4'b0001, a);
    xfer(4'b0010, d);
    xfer(4'b1000, 16'h0);
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [15:0] v);
    xfer(4'b0001, a);
    xfer(4'b0100, 16'h0);
    v = rd_data;
  endtask

  function automatic logic [15:0] pattern(input int p);
    return 16'(p * 16'h2F1B) ^ 16'(p << 13) ^ 16'hA5C3;
  endfunction

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] keep;
    int seen;
    map_addr[0] = 16'h0015; model[0] = 16'h0009;
    map_addr[1] = 16'h0012; model[1] = 16'h8000;
    map_addr[2] = 16'h1010; model[2] = 16'h0080;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of outputs
    check(ack == 0, "R1 ack reset", ack, 0);
    check(rd_data == 0, "R1 rd_data reset", rd_data, 0);
    check(err_flag == 0, "R1 err reset", err_flag, 0);
    // R1 reset values of mapped registers
    for (int i = 0; i < 3; i++) begin
      rd_reg(map_addr[i], v);
      check(v == model[i], "R1 reset register value", v, model[i]);
    end

    // R5 R6 write/read sweep over mapped registers
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 3; i++) begin
        model[i] = pattern(p + i * 8);
        wr_reg(map_addr[i], model[i]);
      end
      for (int i = 2; i >= 0; i--) begin
        rd_reg(map_addr[i], v);
        check(v == model[i], "R5 written value read back", v, model[i]);
      end
    end
    // R5 boundary data values
    wr_reg(map_addr[0], 16'hFFFF); model[0] = 16'hFFFF;
    wr_reg(map_addr[1], 16'h0000); model[1] = 16'h0000;
    rd_reg(map_addr[0], v); check(v == 16'hFFFF, "R5 all ones", v, 16'hFFFF);
    rd_reg(map_addr[1], v); check(v == 16'h0000, "R5 all zeros", v, 0);

    // R6 rd_data holds across non-read traffic
    keep = rd_data;
    wr_reg(map_addr[2], 16'h1234); model[2] = 16'h1234;
    check(rd_data == keep, "R6 rd_data held across write", rd_data, keep);

    // R7 unmapped addresses
    for (int k = 0; k < 6; k++) begin
      logic [15:0] ua;
      case (k)
        0: ua = 16'h0000; 1: ua = 16'h0014; 2: ua = 16'h0016;
        3: ua = 16'h1011; 4: ua = 16'h100F; default: ua = 16'hFFFF;
      endcase
      wr_reg(ua, 16'h5A5A ^ 16'(k));
      rd_reg(ua, v);
      check(v == 0, "R7 unmapped read zero", v, 0);
    end
    for (int i = 0; i < 3; i++) begin
      rd_reg(map_addr[i], v);
      check(v == model[i], "R7 mapped regs untouched", v, model[i]);
    end

    // R2 holding registers: data captured once, used by two writes
    xfer(4'b0010, 16'h0F0F);
    xfer(4'b0001, map_addr[0]); xfer(4'b1000, 16'hAAAA);
    xfer(4'b0001, map_addr[2]); xfer(4'b1000, 16'hBBBB);
    model[0] = 16'h0F0F; model[2] = 16'h0F0F;
    rd_reg(map_addr[0], v); check(v == 16'h0F0F, "R2 data hold reg", v, 16'h0F0F);
    rd_reg(map_addr[2], v); check(v == 16'h0F0F, "R2 data hold reg", v, 16'h0F0F);

    // R8 multi-strobe words
    wr_reg(map_addr[1], 16'h7777); model[1] = 16'h7777;
    keep = rd_data;
    xfer(4'b0011, map_addr[0]);
    check(err_flag == 1, "R8 err raised", err_flag, 1);
    check(rd_data == keep, "R8 rd_data untouched", rd_data, keep);
    xfer(4'b1100, 16'h0);
    check(rd_data == keep, "R8 read suppressed", rd_data, keep);
    xfer(4'b1000, 16'h0);
    rd_reg(map_addr[1], v); check(v == 16'h7777, "R8 addr hold unchanged", v, 16'h7777);
    rd_reg(map_addr[0], v); check(v == model[0], "R8 no write done", v, model[0]);
    check(err_flag == 1, "R8 err sticky", err_flag, 1);

    // R9 mute: read of 0x0012 never acked, no effect
    rd_reg(map_addr[0], v);
    keep = rd_data;
    xfer(4'b0001, map_addr[1]);
    ack_mute = 1;
    @(negedge clk);
    {stb_wr, stb_rd, stb_data, stb_addr} = 4'b0100;
    seen = 0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (ack) seen++;
    end
    check(seen == 0, "R9 no ack while muted", seen, 0);
    {stb_wr, stb_rd, stb_data, stb_addr} = 4'b0000;
    @(negedge clk);
    ack_mute = 0;
    @(negedge clk);
    check(ack == 0, "R9 idle after abandon", ack, 0);
    check(rd_data == keep, "R9 muted read not done", rd_data, keep);
    xfer(4'b0100, 16'h0);
    check(rd_data == model[1], "R9 recovery read", rd_data, model[1]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule